// File: doc/BRIEF.md
# Board Control Register Block

This block is the register file that a processor evaluation board exposes on its local bus. It holds an 8-LED bar, an eight-character ASCII display buffer, a break/reset control byte, a general-purpose output byte and a small set of registers that bit-bang an I2C bus. It also has a guarded software reset that fires only when one exact value is written.

The display buffer can be loaded in two ways. A whole 32-bit word can be written, and the block turns it into eight uppercase hexadecimal characters. Each character position can also be written on its own. The I2C registers drive the clock and data pins directly from a stored output word. The data line is read back through an input register. A general-purpose input register mirrors the I2C output word only while a select bit is set.

The bus port decodes the low 20 address bits. A read returns its data in the cycle after the request. Offsets that are not mapped read as zero, and writes to them are dropped.

Top module: `brd_ctrl_regs`

## Requirements
- R1: Only address bits [19:0] take part in decoding, so an access with any value in the upper address bits reaches the same register as its low-20-bit offset.
- R2: Reads of an unmapped offset return zero, and writes to one change no output and no readable register. Offset 0x41C counts as unmapped. The write-only display offsets also read as zero.
- R3: The switch register (0x200) and the jumper register (0x210) always read zero, and writes to them are ignored.
- R4: The status register (0x208) reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R5: The LED register (0x408) keeps the low 8 bits of a write, drives them on `led_o`, reads them back, and resets to 0x00.
- R6: A write to 0x410 loads display position k (k = 0..7) with the uppercase ASCII hex digit of write bits [31-4k:28-4k], so the most significant nibble lands in position 0. Position k appears on `disp_o[8k+7:8k]`.
- R7: Display position k can be written alone at offset 0x418 + 8k, taking write bits [7:0]. After reset every position holds 0x20.
- R8: A write of exactly 0x00000042 to offset 0x500 raises `sys_rst_req_o` for one cycle, in the cycle after the write. Any other value does nothing.
- R9: The break register (0x508, `brk_o`) holds 8 bits and resets to 0x0A. The general-purpose output (0xA00, `gpo_o`) holds 8 bits and resets to 0x00. Both read back.
- R10: The I2C output-enable register (0xB08, `i2c_oe_o`) holds write bits [1:0] and resets to 0. The select register (0xB18) holds write bit 0 and resets to 1. Both read back.
- R11: The I2C output register (0xB10) stores the full 32-bit write and reads it back. It drives `i2c_scl_o` from bit 1 and `i2c_sda_o` from bit 0, and resets to 0x3.
- R12: The I2C input register (0xB00) reads 0x2 with bit 0 replaced by the level of `i2c_sda_i` sampled at the read.
- R13: The general-purpose input register (0xA08) returns the I2C output word while the select bit is 1, and zero while it is 0.
- R14: A read request gives `bus_rvalid` high with the data in the cycle that follows. A write sees its effect on outputs from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 32 | Byte address; low 20 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| led_o | output | 8 | LED bar |
| disp_o | output | 64 | Display characters, position k at bits [8k+7:8k] |
| brk_o | output | 8 | Break/reset control byte |
| gpo_o | output | 8 | General-purpose output byte |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| i2c_scl_o | output | 1 | I2C clock level |
| i2c_sda_o | output | 1 | I2C data level |
| i2c_oe_o | output | 2 | I2C output enables |
| i2c_sda_i | input | 1 | Live I2C data line |

## Verification
The assertions assume that the bus strobes are held low while reset is asserted. They also assume that each strobe is a clean single-cycle pulse with its address and data stable for that cycle. The bench drives every input on the falling edge, keeps all strobes low through reset, and never issues a read and a write in the same cycle. This keeps the checks free of read-during-write ordering questions. It also holds `i2c_sda_i` steady across each read, so the sampled level is unambiguous.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;

    // Register offsets within the decoded window
    localparam int unsigned OFF_SWITCH  = 'h00200;
    localparam int unsigned OFF_STATUS  = 'h00208;
    localparam int unsigned OFF_JUMPER  = 'h00210;
    localparam int unsigned OFF_LED     = 'h00408;
    localparam int unsigned OFF_HEXWORD = 'h00410;
    localparam int unsigned OFF_CHAR0   = 'h00418;
    localparam int unsigned CHAR_STEP   = 8;
    localparam int unsigned OFF_SOFTRST = 'h00500;
    localparam int unsigned OFF_BRK     = 'h00508;
    localparam int unsigned OFF_GPO     = 'h00A00;
    localparam int unsigned OFF_GPIN    = 'h00A08;
    localparam int unsigned OFF_I2CIN   = 'h00B00;
    localparam int unsigned OFF_I2COE   = 'h00B08;
    localparam int unsigned OFF_I2COUT  = 'h00B10;
    localparam int unsigned OFF_I2CSEL  = 'h00B18;

    // Constants
    localparam logic [7:0]  SOFTRST_KEY  = 8'h42;
    localparam logic [7:0]  STATUS_BE    = 8'h12;
    localparam logic [7:0]  STATUS_LE    = 8'h10;
    localparam logic [7:0]  ASCII_SPACE  = 8'h20;
    localparam logic [7:0]  BRK_RST      = 8'h0A;
    localparam logic [1:0]  I2CIN_STORED = 2'b11;
    localparam logic [1:0]  I2COUT_RST   = 2'b11;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_SWITCH,
        RID_STATUS,
        RID_JUMPER,
        RID_LED,
        RID_HEXWORD,
        RID_CHAR,
        RID_SOFTRST,
        RID_BRK,
        RID_GPO,
        RID_GPIN,
        RID_I2CIN,
        RID_I2COE,
        RID_I2COUT,
        RID_I2CSEL
    } reg_id_e;

endpackage

// File: rtl/brd_addr_dec.sv
module brd_addr_dec
    import brd_ctrl_pkg::*;
#(
    parameter int unsigned DEC_W   = 20,
    parameter int unsigned N_CHARS = 8,
    localparam int unsigned IDX_W  = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
    input  logic [DEC_W-1:0] off,
    output reg_id_e          reg_id,
    output logic [IDX_W-1:0] char_idx
);

    localparam logic [DEC_W-1:0] CHAR_FIRST = DEC_W'(OFF_CHAR0);
    localparam logic [DEC_W-1:0] CHAR_LAST  = DEC_W'(OFF_CHAR0 + CHAR_STEP * (N_CHARS - 1));

    logic is_char;

    always_comb begin
        is_char  = (off >= CHAR_FIRST) && (off <= CHAR_LAST) && (off[2:0] == 3'b000);
        char_idx = IDX_W'((off >> 3) - (CHAR_FIRST >> 3));
        reg_id   = RID_NONE;
        if (is_char) begin
            reg_id = RID_CHAR;
        end else begin
            case (off)
                DEC_W'(OFF_SWITCH):  reg_id = RID_SWITCH;
                DEC_W'(OFF_STATUS):  reg_id = RID_STATUS;
                DEC_W'(OFF_JUMPER):  reg_id = RID_JUMPER;
                DEC_W'(OFF_LED):     reg_id = RID_LED;
                DEC_W'(OFF_HEXWORD): reg_id = RID_HEXWORD;
                DEC_W'(OFF_SOFTRST): reg_id = RID_SOFTRST;
                DEC_W'(OFF_BRK):     reg_id = RID_BRK;
                DEC_W'(OFF_GPO):     reg_id = RID_GPO;
                DEC_W'(OFF_GPIN):    reg_id = RID_GPIN;
                DEC_W'(OFF_I2CIN):   reg_id = RID_I2CIN;
                DEC_W'(OFF_I2COE):   reg_id = RID_I2COE;
                DEC_W'(OFF_I2COUT):  reg_id = RID_I2COUT;
                DEC_W'(OFF_I2CSEL):  reg_id = RID_I2CSEL;
                default:             reg_id = RID_NONE;
            endcase
        end
    end

endmodule

// File: rtl/brd_hex_ascii.sv
module brd_hex_ascii #(
    parameter int unsigned N_DIGITS = 8
) (
    input  logic [4*N_DIGITS-1:0]       word,
    output logic [N_DIGITS-1:0][7:0]    chars
);

    // Digit k of the output takes the k-th nibble counted from the top.
    for (genvar k = 0; k < N_DIGITS; k++) begin : g_digit
        logic [3:0] nib;
        assign nib = word[4*(N_DIGITS-1-k) +: 4];
        assign chars[k] = (nib < 4'd10) ? (8'h30 + {4'h0, nib})
                                        : (8'h37 + {4'h0, nib});
    end

endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
    import brd_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned DEC_W      = 20,
    parameter bit          BIG_ENDIAN = 1'b1,
    localparam int unsigned N_CHARS   = DATA_W / 4,
    localparam int unsigned IDX_W     = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    output logic [7:0]            led_o,
    output logic [N_CHARS*8-1:0]  disp_o,
    output logic [7:0]            brk_o,
    output logic [7:0]            gpo_o,
    output logic                  sys_rst_req_o,
    output logic                  i2c_scl_o,
    output logic                  i2c_sda_o,
    output logic [1:0]            i2c_oe_o,
    input  logic                  i2c_sda_i
);

    typedef struct packed {
        logic [7:0]               led;
        logic [N_CHARS-1:0][7:0]  disp;
        logic [7:0]               brk;
        logic [7:0]               gpo;
        logic [1:0]               i2c_oe;
        logic [DATA_W-1:0]        i2c_out;
        logic                     i2c_sel;
        logic                     rst_req;
        logic                     rvalid;
        logic [DATA_W-1:0]        rdata;
    } state_t;

    state_t s_d, s_q;

    reg_id_e                  reg_id;
    logic [IDX_W-1:0]         char_idx;
    logic [N_CHARS-1:0][7:0]  hex_chars;
    logic [DATA_W-1:0]        rd_val;
    logic                     unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:DEC_W];

    brd_addr_dec #(
        .DEC_W   (DEC_W),
        .N_CHARS (N_CHARS)
    ) u_dec (
        .off      (bus_addr[DEC_W-1:0]),
        .reg_id   (reg_id),
        .char_idx (char_idx)
    );

    brd_hex_ascii #(
        .N_DIGITS (N_CHARS)
    ) u_hex (
        .word  (bus_wdata),
        .chars (hex_chars)
    );

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        case (reg_id)
            RID_SWITCH: rd_val = '0;
            RID_JUMPER: rd_val = '0;
            RID_STATUS: rd_val = DATA_W'(BIG_ENDIAN ? STATUS_BE : STATUS_LE);
            RID_LED:    rd_val = DATA_W'(s_q.led);
            RID_BRK:    rd_val = DATA_W'(s_q.brk);
            RID_GPO:    rd_val = DATA_W'(s_q.gpo);
            RID_GPIN:   rd_val = s_q.i2c_sel ? s_q.i2c_out : '0;
            RID_I2CIN:  rd_val = DATA_W'({I2CIN_STORED[1], i2c_sda_i});
            RID_I2COE:  rd_val = DATA_W'(s_q.i2c_oe);
            RID_I2COUT: rd_val = s_q.i2c_out;
            RID_I2CSEL: rd_val = DATA_W'(s_q.i2c_sel);
            default:    rd_val = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        s_d         = s_q;
        s_d.rst_req = 1'b0;
        s_d.rvalid  = bus_rd;
        if (bus_rd) begin
            s_d.rdata = rd_val;
        end
        if (bus_wr) begin
            case (reg_id)
                RID_LED:     s_d.led = bus_wdata[7:0];
                RID_HEXWORD: s_d.disp = hex_chars;
                RID_CHAR:    s_d.disp[char_idx] = bus_wdata[7:0];
                RID_SOFTRST: s_d.rst_req = (bus_wdata == DATA_W'(SOFTRST_KEY));
                RID_BRK:     s_d.brk = bus_wdata[7:0];
                RID_GPO:     s_d.gpo = bus_wdata[7:0];
                RID_I2COE:   s_d.i2c_oe = bus_wdata[1:0];
                RID_I2COUT:  s_d.i2c_out = bus_wdata;
                RID_I2CSEL:  s_d.i2c_sel = bus_wdata[0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q         <= '0;
            s_q.brk     <= BRK_RST;
            s_q.i2c_out <= DATA_W'(I2COUT_RST);
            s_q.i2c_sel <= 1'b1;
            for (int k = 0; k < N_CHARS; k++) begin
                s_q.disp[k] <= ASCII_SPACE;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata     = s_q.rdata;
    assign bus_rvalid    = s_q.rvalid;
    assign led_o         = s_q.led;
    assign disp_o        = s_q.disp;
    assign brk_o         = s_q.brk;
    assign gpo_o         = s_q.gpo;
    assign sys_rst_req_o = s_q.rst_req;
    assign i2c_scl_o     = s_q.i2c_out[1];
    assign i2c_sda_o     = s_q.i2c_out[0];
    assign i2c_oe_o      = s_q.i2c_oe;

endmodule

// File: rtl/brd_ctrl_chk.sv
module brd_ctrl_chk
    import brd_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEC_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DEC_W-1:0]  off,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [7:0]        led_o,
    input logic              sys_rst_req_o,
    input logic              i2c_scl_o,
    input logic              i2c_sda_o
);

    // R8: the request never lasts two cycles
    p_rst_single_r8: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req_o |=> !sys_rst_req_o);

    // R8: the request only follows the key written to the soft-reset offset
    p_rst_cause_r8: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req_o |-> $past(bus_wr && off == DEC_W'(OFF_SOFTRST)
                                && bus_wdata == DATA_W'(SOFTRST_KEY)));

    // R5: the LED bar only moves after a write to its offset
    p_led_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr && off == DEC_W'(OFF_LED)) |-> $stable(led_o));

    // R11: the I2C pins only move after a write to the output register
    p_pins_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr && off == DEC_W'(OFF_I2COUT)) |-> $stable({i2c_scl_o, i2c_sda_o}));

    // R14: read data is flagged exactly one cycle after the request
    p_rvalid_rise_r14: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) |-> bus_rvalid);
    p_rvalid_idle_r14: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> !bus_rvalid);

    // R3: the switch register reads zero
    p_switch_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && off == DEC_W'(OFF_SWITCH)) |-> bus_rdata == '0);

endmodule

bind brd_ctrl_regs brd_ctrl_chk #(
    .DATA_W (DATA_W),
    .DEC_W  (DEC_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .off           (bus_addr[DEC_W-1:0]),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .led_o         (led_o),
    .sys_rst_req_o (sys_rst_req_o),
    .i2c_scl_o     (i2c_scl_o),
    .i2c_sda_o     (i2c_sda_o)
);

// File: tb/tb_brd_ctrl_regs.sv
module tb_brd_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  led_o;
    logic [63:0] disp_o;
    logic [7:0]  brk_o;
    logic [7:0]  gpo_o;
    logic        sys_rst_req_o;
    logic        i2c_scl_o;
    logic        i2c_sda_o;
    logic [1:0]  i2c_oe_o;
    logic        i2c_sda_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    brd_ctrl_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .led_o(led_o), .disp_o(disp_o),
        .brk_o(brk_o), .gpo_o(gpo_o), .sys_rst_req_o(sys_rst_req_o),
        .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_oe_o(i2c_oe_o),
        .i2c_sda_i(i2c_sda_i)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and queue the value the requirements predict
    task automatic do_rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: compare returned data against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R14 unexpected rvalid", 64'(bus_rvalid), 64'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    function automatic logic [63:0] hex_disp(input logic [31:0] w);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) begin
            logic [3:0] n;
            n = w[31-4*k -: 4];
            r[8*k +: 8] = (n < 10) ? 8'(8'd48 + 8'(n)) : 8'(8'd55 + 8'(n));
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [63:0] disp_exp;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R5 led reset", 64'(led_o), 64'h00);
        check("R7 display reset spaces", disp_o, {8{8'h20}});
        check("R9 brk reset", 64'(brk_o), 64'h0A);
        check("R9 gpo reset", 64'(gpo_o), 64'h00);
        check("R10 oe reset", 64'(i2c_oe_o), 64'h0);
        check("R11 pins reset", 64'({i2c_scl_o, i2c_sda_o}), 64'h3);
        check("R8 no request at reset", 64'(sys_rst_req_o), 64'h0);
        do_rd(32'h0000_0B18, 32'h1, "R10 sel reset readback");
        do_rd(32'h0000_0B08, 32'h0, "R10 oe reset readback");
        do_rd(32'h0000_0B10, 32'h3, "R11 out reset readback");
        do_rd(32'h0000_0508, 32'h0A, "R9 brk reset readback");
        do_rd(32'h0000_0A00, 32'h00, "R9 gpo reset readback");

        // Fixed registers
        do_rd(32'h0000_0208, 32'h12, "R4 status big-endian");
        do_rd(32'h0000_0200, 32'h0, "R3 switch reads zero");
        do_wr(32'h0000_0200, 32'hFFFF_FFFF);
        do_rd(32'h0000_0200, 32'h0, "R3 switch after write");
        do_wr(32'h0000_0210, 32'h1234_5678);
        do_rd(32'h0000_0210, 32'h0, "R3 jumper after write");

        // LED and aliasing
        do_wr(32'h0000_0408, 32'h0000_01A5);
        check("R5 led low byte", 64'(led_o), 64'hA5);
        do_rd(32'h0000_0408, 32'hA5, "R5 led readback");
        do_wr(32'h1F00_0408, 32'h0000_003C);
        check("R1 aliased write", 64'(led_o), 64'h3C);
        do_rd(32'hFFF0_0408, 32'h3C, "R1 aliased read");

        // Unmapped offsets
        do_wr(32'h0000_0404, 32'hFFFF_FFFF);
        check("R2 unmapped write leaves led", 64'(led_o), 64'h3C);
        do_rd(32'h0000_0404, 32'h0, "R2 unmapped read");
        do_rd(32'h0000_0418, 32'h0, "R2 display offset reads zero");

        // Hex word display
        do_wr(32'h0000_0410, 32'h9AF0_3C5D);
        disp_exp = hex_disp(32'h9AF0_3C5D);
        check("R6 hex word display", disp_o, disp_exp);
        check("R6 position 0 is top nibble", 64'(disp_o[7:0]), 64'h39);
        check("R6 position 7 is bottom nibble", 64'(disp_o[63:56]), 64'h44);

        // Per-character writes
        do_wr(32'h0000_0418 + 3*8, 32'h1234_5647);
        disp_exp[31:24] = 8'h47;
        check("R7 char position 3", disp_o, disp_exp);
        do_wr(32'h0000_0450, 32'h0000_007A);
        disp_exp[63:56] = 8'h7A;
        check("R7 char position 7", disp_o, disp_exp);
        do_wr(32'h0000_041C, 32'h0000_0055);
        check("R2 misaligned char offset ignored", disp_o, disp_exp);

        // Software reset
        do_wr(32'h0000_0500, 32'h0000_0042);
        check("R8 request pulse", 64'(sys_rst_req_o), 64'h1);
        @(negedge clk);
        check("R8 request single cycle", 64'(sys_rst_req_o), 64'h0);
        do_wr(32'h0000_0500, 32'h0000_0142);
        check("R8 wrong value no request", 64'(sys_rst_req_o), 64'h0);
        do_wr(32'h0000_0500, 32'h0000_0041);
        check("R8 near value no request", 64'(sys_rst_req_o), 64'h0);

        // Break and GP output
        do_wr(32'h0000_0508, 32'h0000_01FF);
        check("R9 brk write", 64'(brk_o), 64'hFF);
        do_wr(32'h0000_0A00, 32'hABCD_EF5A);
        check("R9 gpo write", 64'(gpo_o), 64'h5A);
        do_rd(32'h0000_0A00, 32'h5A, "R9 gpo readback");

        // I2C registers
        do_wr(32'h0000_0B08, 32'h0000_000F);
        check("R10 oe two bits", 64'(i2c_oe_o), 64'h3);
        do_rd(32'h0000_0B08, 32'h3, "R10 oe readback");
        do_wr(32'h0000_0B10, 32'h0000_0002);
        check("R11 scl high sda low", 64'({i2c_scl_o, i2c_sda_o}), 64'h2);
        do_rd(32'h0000_0B10, 32'h2, "R11 out readback");
        do_rd(32'h0000_0A08, 32'h2, "R13 gp input mirrors with select 1");
        do_wr(32'h0000_0B18, 32'h0000_0002);
        do_rd(32'h0000_0B18, 32'h0, "R10 select cleared");
        do_rd(32'h0000_0A08, 32'h0, "R13 gp input zero with select 0");
        do_wr(32'h0000_0B18, 32'hFFFF_FFFF);
        do_rd(32'h0000_0B18, 32'h1, "R10 select one bit");
        do_wr(32'h0000_0B10, 32'hABCD_0001);
        check("R11 scl low sda high", 64'({i2c_scl_o, i2c_sda_o}), 64'h1);
        do_rd(32'h0000_0B10, 32'hABCD_0001, "R11 full word readback");
        do_rd(32'h0000_0A08, 32'hABCD_0001, "R13 gp input full word");
        i2c_sda_i = 1'b0;
        do_rd(32'h0000_0B00, 32'h2, "R12 input with sda low");
        i2c_sda_i = 1'b1;
        do_rd(32'h0000_0B00, 32'h3, "R12 input with sda high");

        repeat (3) @(negedge clk);
        check("R14 all reads answered", 64'(exp_q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule